// File: doc/BRIEF.md
# Segment Limit Check and Linear Address Unit

This unit sits in the address path of a protected-mode segmented CPU model. It receives the cached fields of a segment descriptor and an effective offset with an access width. It returns the linear address and a limit-violation verdict. The descriptor fields are a 32-bit base, a 20-bit limit, a granularity bit, a big (B) bit, an expand-down bit and a stack-segment flag. The access width is 1, 2 or 4 bytes. The linear address is always the base plus the offset, wrapped to 32 bits, whatever the segment direction. Only the window of legal offsets depends on the segment type.

For an expand-up segment, every byte of the access must lie at or below the effective limit. For an expand-down segment the window is inverted. Legal offsets start just above the effective limit and run up to 0xFFFF or 0xFFFFFFFF, as the B bit selects. A violation on a stack segment is reported as a stack fault, and any other violation as a general-protection fault.

The unit takes a one-cycle request strobe. It registers the address, the fault flag and the fault type together and presents them with a valid pulse on the next clock edge.

Top module: `seg_addr_unit`

## Requirements
- R1: For every request, `lin_addr` equals (`seg_base` + `offset`) mod 2^32, for expand-up and expand-down segments alike.
- R2: The effective limit is `seg_limit` zero-extended when `seg_gran`=0. When `seg_gran`=1 it is `seg_limit` shifted left by 12 with the low 12 bits set to one.
- R3: For an expand-up segment (`seg_down`=0), the access faults exactly when `offset` + bytes - 1, computed without wrap, exceeds the effective limit. `seg_big` has no effect on this check.
- R4: For an expand-down segment, an `offset` less than or equal to the effective limit faults.
- R5: For an expand-down segment, the access faults when `offset` + bytes - 1, computed without wrap, exceeds 0xFFFF with `seg_big`=0, or exceeds 0xFFFFFFFF with `seg_big`=1. With `seg_big`=0, any offset bit set above bit 15 therefore faults.
- R6: When the access faults, `fault_stack` is 1 if `seg_stack`=1 and 0 otherwise. When it does not fault, both `fault` and `fault_stack` are 0.
- R7: An expand-down segment with `seg_big`=0, `seg_gran`=0 and limit 0xFFFF faults for every offset and width.
- R8: `acc_size` encodes the width: 2'b00 is 1 byte, 2'b01 is 2 bytes, 2'b10 and 2'b11 are 4 bytes.
- R9: `res_valid` is high for exactly the cycle after each cycle in which `req_valid` is high. `lin_addr`, `fault` and `fault_stack` update only on those edges and otherwise hold.
- R10: After reset, `res_valid`, `fault`, `fault_stack` and `lin_addr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| seg_base | input | 32 | Segment base |
| seg_limit | input | 20 | Raw segment limit |
| seg_gran | input | 1 | Limit counted in 4 KiB units |
| seg_big | input | 1 | Selects 0xFFFFFFFF instead of 0xFFFF as expand-down top |
| seg_down | input | 1 | Expand-down segment |
| seg_stack | input | 1 | Segment is the stack segment |
| offset | input | 32 | Effective offset |
| acc_size | input | 2 | Access width code |
| res_valid | output | 1 | Result valid pulse |
| lin_addr | output | 32 | Linear address |
| fault | output | 1 | Limit violation |
| fault_stack | output | 1 | Violation is a stack fault (else general protection) |

## Verification
A vector table walks both segment directions across the edges that separate them: the limit itself, limit+1, 0xFFFF and 0xFFFFFFFF. These cases tell an off-by-one in the lower bound apart from a missing check of the last byte. They also tell a wrong B-bit top apart from an address path that subtracts a length from the base. A base of 0x80000000 with offset 0xFFFFFFFF separates a correct wrap from a widened sum. Granular limits on both directions catch a wrong fill of the low bits. Random descriptors, with offsets placed near the effective limit and near the top, are then compared against a reference model, and idle cycles confirm that the outputs hold.

// File: rtl/seg_addr_unit.sv
module seg_addr_unit #(
  parameter int OFS_W  = 32,
  parameter int LIM_W  = 20,
  parameter int GRAN_W = 12,
  parameter int SMALL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [OFS_W-1:0] seg_base,
  input  logic [LIM_W-1:0] seg_limit,
  input  logic             seg_gran,
  input  logic             seg_big,
  input  logic             seg_down,
  input  logic             seg_stack,
  input  logic [OFS_W-1:0] offset,
  input  logic [1:0]       acc_size,
  output logic             res_valid,
  output logic [OFS_W-1:0] lin_addr,
  output logic             fault,
  output logic             fault_stack
);

  localparam logic [OFS_W:0] SMALL_TOP = {{(OFS_W+1-SMALL_W){1'b0}}, {SMALL_W{1'b1}}};
  localparam logic [OFS_W:0] BIG_TOP   = {1'b0, {OFS_W{1'b1}}};

  logic [OFS_W-1:0] eff_limit;
  logic [2:0]       nbytes;
  logic [OFS_W:0]   last_byte;
  logic [OFS_W:0]   down_top;
  logic             up_bad, down_bad, bad;

  assign eff_limit = seg_gran ? {seg_limit, {GRAN_W{1'b1}}}
                              : {{(OFS_W-LIM_W){1'b0}}, seg_limit};

  always_comb begin
    case (acc_size)
      2'b00:   nbytes = 3'd1;
      2'b01:   nbytes = 3'd2;
      default: nbytes = 3'd4;
    endcase
  end

  assign last_byte = {1'b0, offset} + {{(OFS_W-2){1'b0}}, nbytes} - 1'b1;
  assign down_top  = seg_big ? BIG_TOP : SMALL_TOP;

  assign up_bad   = last_byte > {1'b0, eff_limit};
  assign down_bad = (offset <= eff_limit) || (last_byte > down_top);
  assign bad      = seg_down ? down_bad : up_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      lin_addr    <= '0;
      fault       <= 1'b0;
      fault_stack <= 1'b0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        lin_addr    <= seg_base + offset;
        fault       <= bad;
        fault_stack <= bad & seg_stack;
      end
    end
  end

  // R1
  addr_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> lin_addr == $past(seg_base + offset));

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);

  // R9
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid && $stable(lin_addr) && $stable(fault) && $stable(fault_stack));

  // R6
  stack_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_stack |-> fault);

  // R6
  gp_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !seg_stack |=> !fault_stack);

  // R7
  empty_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && seg_down && !seg_big && !seg_gran && seg_limit == 20'h0FFFF |=> fault);

  // R4
  down_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && seg_down && !seg_gran && offset <= {12'h000, seg_limit} |=> fault);

endmodule

// File: tb/sim_seg_addr_unit.sv
module sim_seg_addr_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 18;

  logic        clk = 0, rst_n = 0, req_valid = 0;
  logic [31:0] seg_base = 0, offset = 0;
  logic [19:0] seg_limit = 0;
  logic        seg_gran = 0, seg_big = 0, seg_down = 0, seg_stack = 0;
  logic [1:0]  acc_size = 0;
  logic        res_valid, fault, fault_stack;
  logic [31:0] lin_addr;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_addr_unit u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .seg_base(seg_base), .seg_limit(seg_limit), .seg_gran(seg_gran),
    .seg_big(seg_big), .seg_down(seg_down), .seg_stack(seg_stack),
    .offset(offset), .acc_size(acc_size),
    .res_valid(res_valid), .lin_addr(lin_addr), .fault(fault), .fault_stack(fault_stack)
  );

  // {base, limit, gran, big, down, stack, offset, size, exp_fault, exp_stack}
  localparam logic [91:0] VEC [NVEC] = '{
    {32'h80000000, 20'h0FFFF, 4'b0000, 32'h0000FFFC, 2'b10, 2'b00},
    {32'h80000000, 20'h0FFFF, 4'b0000, 32'h0000FFFD, 2'b10, 2'b10},
    {32'h80000000, 20'h0FFFF, 4'b0100, 32'h0000FFFD, 2'b10, 2'b10},
    {32'h00100000, 20'h00FFF, 4'b0011, 32'h00000FFF, 2'b00, 2'b11},
    {32'h00100000, 20'h00FFF, 4'b0011, 32'h00001000, 2'b00, 2'b00},
    {32'h00100000, 20'h00FFF, 4'b0010, 32'h0000FFFF, 2'b00, 2'b00},
    {32'h00100000, 20'h00FFF, 4'b0010, 32'h0000FFFE, 2'b01, 2'b00},
    {32'h00100000, 20'h00FFF, 4'b0010, 32'h0000FFFE, 2'b10, 2'b10},
    {32'h00100000, 20'h00FFF, 4'b0010, 32'h00010000, 2'b00, 2'b10},
    {32'h80000000, 20'h00FFF, 4'b0110, 32'hFFFFFFFF, 2'b00, 2'b00},
    {32'h80000000, 20'h00FFF, 4'b0111, 32'hFFFFFFFE, 2'b11, 2'b11},
    {32'h00200000, 20'h0FFFF, 4'b0010, 32'h0000FFFF, 2'b00, 2'b10},
    {32'h00200000, 20'h00001, 4'b1000, 32'h00001FFF, 2'b00, 2'b00},
    {32'h00200000, 20'h00001, 4'b1000, 32'h00002000, 2'b00, 2'b10},
    {32'h00200000, 20'h00001, 4'b1110, 32'h00001FFF, 2'b00, 2'b10},
    {32'h00200000, 20'h00001, 4'b1110, 32'h00002000, 2'b00, 2'b00},
    {32'h00000000, 20'h00010, 4'b0001, 32'h00000010, 2'b01, 2'b11},
    {32'hF0000000, 20'hFFFFF, 4'b1000, 32'hFFFFFFFF, 2'b01, 2'b10}
  };

  function automatic string vec_tag(int i);
    case (i)
      0, 1, 2, 17: return "R3";
      3:           return "R4/R6";
      4:           return "R4";
      5, 8, 9, 10: return "R5";
      6, 7:        return "R8";
      11:          return "R7";
      16:          return "R6";
      default:     return "R2";
    endcase
  endfunction

  function automatic logic ref_fault(logic [19:0] lim, logic g, logic b, logic dn,
                                     logic [31:0] off, logic [1:0] sz);
    logic [32:0] eff, last, top;
    eff  = g ? {1'b0, lim, 12'hFFF} : {13'd0, lim};
    last = {1'b0, off} + ((sz == 2'b00) ? 33'd0 : (sz == 2'b01) ? 33'd1 : 33'd3);
    top  = b ? 33'h0FFFFFFFF : 33'h00000FFFF;
    if (!dn) return last > eff;
    return ({1'b0, off} <= eff) || (last > top);
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic issue(logic [31:0] b, logic [19:0] l, logic g, logic bg, logic dn, logic st,
                       logic [31:0] off, logic [1:0] sz);
    @(negedge clk);
    seg_base = b; seg_limit = l; seg_gran = g; seg_big = bg; seg_down = dn;
    seg_stack = st; offset = off; acc_size = sz; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] hold_addr;
    logic        hold_f, hold_s, ef;
    repeat (3) @(negedge clk);
    // R10
    check("R10", "res_valid", {31'd0, res_valid}, 0);
    check("R10", "lin_addr", lin_addr, 0);
    check("R10", "fault", {31'd0, fault}, 0);
    check("R10", "fault_stack", {31'd0, fault_stack}, 0);
    rst_n = 1;

    for (int i = 0; i < NVEC; i++) begin
      logic [91:0] v;
      v = VEC[i];
      issue(v[91:60], v[59:40], v[39], v[38], v[37], v[36], v[35:4], v[3:2]);
      check("R9", "res_valid", {31'd0, res_valid}, 1);
      check("R1", "lin_addr", lin_addr, v[91:60] + v[35:4]);
      check(vec_tag(i), "fault", {31'd0, fault}, {31'd0, v[1]});
      check(vec_tag(i), "fault_stack", {31'd0, fault_stack}, {31'd0, v[0]});
    end

    // R9: idle cycles leave the result untouched
    hold_addr = lin_addr; hold_f = fault; hold_s = fault_stack;
    @(negedge clk);
    seg_base = 32'h12345678; offset = 32'h0; seg_down = 1; seg_big = 0; seg_limit = 20'h0FFFF;
    @(negedge clk);
    check("R9", "idle res_valid", {31'd0, res_valid}, 0);
    check("R9", "idle lin_addr", lin_addr, hold_addr);
    check("R9", "idle fault", {30'd0, fault, fault_stack}, {30'd0, hold_f, hold_s});

    for (int k = 0; k < 400; k++) begin
      logic [31:0] b, off, eff;
      logic [19:0] l;
      logic g, bg, dn, st;
      logic [1:0] sz;
      b = $urandom; l = $urandom; g = $urandom; bg = $urandom; dn = $urandom;
      st = $urandom; sz = $urandom;
      if (k % 7 == 0) l = 20'h0FFFF;
      if (k % 5 == 0) l = l & 20'h00FFF;
      eff = g ? {l, 12'hFFF} : {12'd0, l};
      case ($urandom % 4)
        0: off = eff + ($urandom % 5) - 2;
        1: off = 32'h0000FFFF - ($urandom % 5);
        2: off = 32'hFFFFFFFF - ($urandom % 5);
        default: off = $urandom;
      endcase
      ef = ref_fault(l, g, bg, dn, off, sz);
      issue(b, l, g, bg, dn, st, off, sz);
      check("R1", "rand lin_addr", lin_addr, b + off);
      check(dn ? "R4/R5" : "R3", "rand fault", {31'd0, fault}, {31'd0, ef});
      check("R6", "rand fault_stack", {31'd0, fault_stack}, {31'd0, ef & st});
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule